// File: doc/BRIEF.md
# Row-Buffer Policy Command Generator

This block turns one decoded memory transaction at a time (rank, bank, row, column, read or write) into the short series of DRAM commands that carries it out: row activation, a plain column read or write, a column read or write that closes the row automatically afterwards, and explicit row precharge. It remembers, for every bank of every rank, whether a row is open and which one. It also keeps per-bank down-counters so that no command breaks the activate-to-column, activate-to-precharge, precharge-to-activate and activate-to-activate minimum intervals.

A two-bit policy code and a one-bit lookahead hint come in with each transaction. The policy picks one of four row-buffer strategies. In close mode every row is closed as soon as it is used. In open mode a used row is left open so that a later access to the same row needs only a column command. In the two aggressive modes the lookahead hint decides: if a younger queued request targets the same row, the row stays open. Otherwise the column access closes it. A downstream scheduler sees one command at a time on a valid/grant pair. The command stays unchanged until it is granted.

Top module: `rowbuf_cmd_gen`

## Requirements
- R1: After reset, `cmd_valid` is 0, `req_ready` is 1, and every bank is closed, so the first transaction to any bank begins with an activate.
- R2: `policy` code 0 (close): a transaction to a closed bank produces an activate (`cmd_kind` 1) and then one auto-precharge column command (4 = read, 5 = write).
- R3: `policy` code 1 (open): a transaction whose row is already open in its bank produces exactly one plain column command (2 = read, 3 = write).
- R4: Under any policy, a transaction to a bank holding a different open row produces a precharge (`cmd_kind` 6), then an activate, then the column command.
- R5: A column command to a bank is granted no sooner than T_RCD cycles after that bank's activate was granted.
- R6: An explicit precharge to a bank is granted no sooner than T_RAS cycles after that bank's activate.
- R7: An activate to a bank is granted no sooner than T_RC cycles after that bank's previous activate, and no sooner than T_RP cycles after an explicit precharge to that bank.
- R8: `policy` codes 2 and 3 (the aggressive modes): the column command is plain when `req_look` was 1 at acceptance, and auto-precharge when it was 0. A later transaction to a row left open this way is a hit.
- R9: After an auto-precharge column command, the next access to that bank, even to the same row, begins with an activate. That activate comes no sooner than T_RAS + T_RP cycles after the previous activate.
- R10: While `cmd_valid` is 1 and `cmd_grant` is 0, the next cycle still shows `cmd_valid` 1 with the same kind, rank, bank, row and column.
- R11: `req_ready` drops in the cycle after a transaction is accepted and stays low until its single column command is granted. `policy` and `req_look` are sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Generator can accept a transaction |
| req_rank | input | RANK_W | Target rank |
| req_bank | input | BANK_W | Target bank within the rank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_look | input | 1 | A younger queued request targets the same row |
| policy | input | 2 | 0 close, 1 open, 2 close-aggressive, 3 open-aggressive |
| cmd_valid | output | 1 | A command is presented |
| cmd_grant | input | 1 | Scheduler takes the presented command this cycle |
| cmd_kind | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 read+AP, 5 write+AP, 6 precharge |
| cmd_rank | output | RANK_W | Command rank |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row (meaningful for activate) |
| cmd_col | output | COL_W | Column (meaningful for column commands) |

## Verification
A wrong open-row record shows up at the very next transaction to that bank. It appears as a missing or extra precharge or activate, or as a column command issued against a row that was never activated. A counter that loads or counts down wrongly shows up as a granted command that is too close to the bank's previous activate or precharge. This is visible in the same grant cycle by comparing grant timestamps per bank. A generator that changes its command while the grant is withheld shows up one cycle later as a changed field under a still-asserted `cmd_valid`.

// File: rtl/rbp_pkg.sv
// Shared command, policy and bank-state encodings for the row-buffer
// command generator. Assumes a 3-bit command code seen by the scheduler.
package rbp_pkg;
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_RDA  = 3'd4,
        CMD_WRA  = 3'd5,
        CMD_PRE  = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        POL_CLOSE      = 2'd0,
        POL_OPEN       = 2'd1,
        POL_CLOSE_AGGR = 2'd2,
        POL_OPEN_AGGR  = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_ACTV = 2'd1,
        BK_OPEN = 2'd2,
        BK_PRE  = 2'd3
    } bank_st_e;
endpackage

// File: rtl/rbp_col_choice.sv
// Picks the column command flavour from the policy, the lookahead hint and
// the access direction. Purely combinational; assumes inputs are latched.
module rbp_col_choice
    import rbp_pkg::*;
(
    input  pol_e pol,
    input  logic look,
    input  logic wr,
    output cmd_e kind
);
    logic keep_open;

    // Decide whether the row survives the access
    always_comb begin
        case (pol)
            POL_CLOSE: keep_open = 1'b0;
            POL_OPEN:  keep_open = 1'b1;
            default:   keep_open = look;
        endcase
    end

    // Map the decision and direction onto a command code
    always_comb begin
        if (keep_open) kind = wr ? CMD_WR  : CMD_RD;
        else           kind = wr ? CMD_WRA : CMD_RDA;
    end
endmodule

// File: rtl/rbp_bank_timer.sv
// One bank: open-row record, state and timing down-counters. Counters load
// on the grant edge and count to zero; a command is legal when its counter
// reads zero. Assumes every timing parameter is at least 1.
module rbp_bank_timer
    import rbp_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             col_go,
    input  logic             colap_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             can_act,
    output logic             can_col,
    output logic             can_pre
);
    localparam int TMAX  = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int TMAX2 = (TMAX > T_RCD) ? ((TMAX > T_RP) ? TMAX : T_RP)
                                          : ((T_RCD > T_RP) ? T_RCD : T_RP);
    localparam int CW    = $clog2(TMAX2 + 1);

    bank_st_e        st;
    logic [CW-1:0]   rcd_c, ras_c, rp_c, rc_c;
    logic            rp_run;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Bank state, open row and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= BK_IDLE;
            open_row <= '0;
            rcd_c    <= '0;
            ras_c    <= '0;
            rp_c     <= '0;
            rc_c     <= '0;
            rp_run   <= 1'b0;
        end else begin
            rcd_c <= dec(rcd_c);
            ras_c <= dec(ras_c);
            rp_c  <= dec(rp_c);
            rc_c  <= dec(rc_c);
            if (act_go) begin
                st       <= BK_ACTV;
                open_row <= act_row;
                rcd_c    <= CW'(T_RCD);
                ras_c    <= CW'(T_RAS);
                rc_c     <= CW'(T_RC);
            end else if (pre_go) begin
                st     <= BK_PRE;
                rp_c   <= CW'(T_RP - 1);
                rp_run <= 1'b1;
            end else if (colap_go) begin
                st     <= BK_PRE;
                rp_run <= 1'b0;
            end else begin
                case (st)
                    BK_ACTV: if (rcd_c == '0) st <= BK_OPEN;
                    BK_PRE: begin
                        if (!rp_run && ras_c == '0) begin
                            rp_c   <= CW'(T_RP - 1);
                            rp_run <= 1'b1;
                        end else if (rp_run && rp_c == '0) begin
                            st     <= BK_IDLE;
                            rp_run <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Legality flags seen by the command selector
    always_comb begin
        is_open = (st == BK_ACTV) || (st == BK_OPEN);
        can_act = (st == BK_IDLE) && (rc_c == '0);
        can_col = is_open && (rcd_c == '0);
        can_pre = is_open && (ras_c == '0);
    end

    // R5
    col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go || colap_go) |-> (is_open && rcd_c == '0));
    // R5
    act_blocks_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> !can_col);
    // R6
    pre_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> (is_open && ras_c == '0));
    // R7
    act_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (st == BK_IDLE && rc_c == '0));
endmodule

// File: rtl/rowbuf_cmd_gen.sv
// Row-buffer policy command generator. Accepts one transaction at a time,
// issues activate / precharge / column commands to a downstream scheduler
// under a valid/grant handshake and tracks every bank's open row. Assumes
// the scheduler alone orders commands across banks and handles refresh.
module rowbuf_cmd_gen
    import rbp_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 6,
    parameter int T_RP   = 3,
    parameter int T_RC   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_look,
    input  logic [1:0]        policy,
    output logic              cmd_valid,
    input  logic              cmd_grant,
    output logic [2:0]        cmd_kind,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    localparam int ID_W = RANK_W + BANK_W;
    localparam int NB   = 1 << ID_W;

    logic             busy;
    logic [ID_W-1:0]  t_id;
    logic [ROW_W-1:0] t_row;
    logic [COL_W-1:0] t_col;
    logic             t_wr, t_look;
    pol_e             t_pol;

    logic [NB-1:0]    b_open, b_can_act, b_can_col, b_can_pre;
    logic [ROW_W-1:0] b_row [NB];

    cmd_e nxt_kind, col_kind;
    logic nxt_ok, fire, is_col;

    rbp_col_choice u_choice (
        .pol  (t_pol),
        .look (t_look),
        .wr   (t_wr),
        .kind (col_kind)
    );

    // One timer per bank of every rank
    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit_id;
        assign hit_id = fire && (t_id == ID_W'(i));
        rbp_bank_timer #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
            .T_RP(T_RP),   .T_RC(T_RC)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_go   (hit_id && nxt_kind == CMD_ACT),
            .col_go   (hit_id && (nxt_kind == CMD_RD  || nxt_kind == CMD_WR)),
            .colap_go (hit_id && (nxt_kind == CMD_RDA || nxt_kind == CMD_WRA)),
            .pre_go   (hit_id && nxt_kind == CMD_PRE),
            .act_row  (t_row),
            .is_open  (b_open[i]),
            .open_row (b_row[i]),
            .can_act  (b_can_act[i]),
            .can_col  (b_can_col[i]),
            .can_pre  (b_can_pre[i])
        );
    end

    // Choose the next command for the held transaction and its legality
    always_comb begin
        if (b_open[t_id] && b_row[t_id] == t_row) begin
            nxt_kind = col_kind;
            nxt_ok   = b_can_col[t_id];
        end else if (b_open[t_id]) begin
            nxt_kind = CMD_PRE;
            nxt_ok   = b_can_pre[t_id];
        end else begin
            nxt_kind = CMD_ACT;
            nxt_ok   = b_can_act[t_id];
        end
    end

    // Handshake and output drive
    always_comb begin
        cmd_valid = busy && nxt_ok;
        fire      = cmd_valid && cmd_grant;
        is_col    = (nxt_kind != CMD_ACT) && (nxt_kind != CMD_PRE);
        req_ready = !busy;
        cmd_kind  = cmd_valid ? nxt_kind : CMD_NONE;
        cmd_rank  = t_id[ID_W-1:BANK_W];
        cmd_bank  = t_id[BANK_W-1:0];
        cmd_row   = t_row;
        cmd_col   = t_col;
    end

    // Transaction holding register: load on accept, release on column grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            t_id   <= '0;
            t_row  <= '0;
            t_col  <= '0;
            t_wr   <= 1'b0;
            t_look <= 1'b0;
            t_pol  <= POL_CLOSE;
        end else if (!busy) begin
            if (req_valid) begin
                busy   <= 1'b1;
                t_id   <= {req_rank, req_bank};
                t_row  <= req_row;
                t_col  <= req_col;
                t_wr   <= req_write;
                t_look <= req_look;
                t_pol  <= pol_e'(policy);
            end
        end else if (fire && is_col) begin
            busy <= 1'b0;
        end
    end

    // R10
    hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_grant) |=> (cmd_valid && $stable(cmd_kind) &&
            $stable(cmd_rank) && $stable(cmd_bank) && $stable(cmd_row) &&
            $stable(cmd_col)));
    // R11
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R11
    ready_only_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !(cmd_valid && cmd_grant && cmd_kind >= 3'd2 &&
                         cmd_kind <= 3'd5)) |=> !req_ready);
    // R1
    idle_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);
endmodule

// File: tb/tb_rowbuf_cmd_gen.sv
module tb_rowbuf_cmd_gen;
    localparam int RANK_W = 1, BANK_W = 2, ROW_W = 8, COL_W = 6;
    localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 9;
    localparam int NB = 1 << (RANK_W + BANK_W);
    localparam int NBK = 1 << BANK_W;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_look = 0, cmd_grant = 0;
    logic [RANK_W-1:0] req_rank = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [1:0]        policy = '0;
    logic req_ready, cmd_valid;
    logic [2:0] cmd_kind;
    logic [RANK_W-1:0] cmd_rank;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;

    rowbuf_cmd_gen #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
        .T_RC(T_RC)) dut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [2:0] kind;
        logic [RANK_W+BANK_W-1:0] id;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int errors = 0, checks = 0, cyc = 0;
    bit stall = 0, finished = 0;
    bit m_open[NB];
    int m_row[NB];

    always @(posedge clk) cyc <= cyc + 1;

    // Grant driver: always or every third cycle
    always @(posedge clk) begin
        #1 cmd_grant = stall ? (cyc % 3 == 2) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic push(input int kind, input int id, input int row, input int col, input string tag);
        item_t it;
        it.kind = 3'(kind); it.id = (RANK_W+BANK_W)'(id);
        it.row = ROW_W'(row); it.col = COL_W'(col);
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // Driver: bank model gives expected commands, then offers the request
    task automatic send(input int rk, input int bk, input int row, input int col,
                        input bit wr, input int pol, input bit look, input string tag);
        int id = rk * NBK + bk;
        int ck;
        bit keep;
        keep = (pol == 0) ? 1'b0 : (pol == 1) ? 1'b1 : look;
        ck = keep ? (wr ? 3 : 2) : (wr ? 5 : 4);
        if (!(m_open[id] && m_row[id] == row)) begin
            if (m_open[id]) push(6, id, row, col, tag);
            push(1, id, row, col, tag);
        end
        push(ck, id, row, col, tag);
        m_open[id] = keep;
        m_row[id] = row;
        do begin @(posedge clk); #1; end while (!req_ready);
        req_valid = 1; req_rank = RANK_W'(rk); req_bank = BANK_W'(bk);
        req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr;
        policy = 2'(pol); req_look = look;
        @(posedge clk); #1;
        req_valid = 0; policy = 2'(3 - pol); req_look = ~look;
        check(req_ready == 0, "R11 ready low after accept", req_ready, 0);
    endtask

    // Monitor: scoreboard compare, timing per bank, hold under stall
    int t_act[NB], t_pre[NB];
    bit had_act[NB], had_pre[NB], ap_pend[NB];
    bit p_wait = 0;
    logic [2:0] p_kind; logic [RANK_W-1:0] p_rank; logic [BANK_W-1:0] p_bank;
    logic [ROW_W-1:0] p_row; logic [COL_W-1:0] p_col;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (p_wait)   // R10
                check(cmd_valid && cmd_kind == p_kind && cmd_rank == p_rank &&
                      cmd_bank == p_bank && cmd_row == p_row && cmd_col == p_col,
                      "R10 held command", cmd_kind, p_kind);
            if (cmd_valid && cmd_grant) begin
                int id;
                id = {cmd_rank, cmd_bank};
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected command", cmd_kind, 0);
                end else begin
                    item_t e;
                    string tg;
                    bit ok;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    ok = (cmd_kind == e.kind) && (id == e.id);
                    if (e.kind == 1) ok = ok && (cmd_row == e.row);
                    if (e.kind >= 2 && e.kind <= 5) ok = ok && (cmd_col == e.col);
                    check(ok, tg, cmd_kind, e.kind);
                end
                case (cmd_kind)
                    3'd1: begin
                        if (had_act[id]) check(cyc - t_act[id] >= T_RC, "R7 ACT-ACT", cyc - t_act[id], T_RC);
                        if (had_pre[id]) check(cyc - t_pre[id] >= T_RP, "R7 PRE-ACT", cyc - t_pre[id], T_RP);
                        if (ap_pend[id]) check(cyc - t_act[id] >= T_RAS + T_RP, "R9 AP-ACT", cyc - t_act[id], T_RAS + T_RP);
                        t_act[id] = cyc; had_act[id] = 1; had_pre[id] = 0; ap_pend[id] = 0;
                    end
                    3'd6: begin
                        check(cyc - t_act[id] >= T_RAS, "R6 ACT-PRE", cyc - t_act[id], T_RAS);
                        t_pre[id] = cyc; had_pre[id] = 1;
                    end
                    default: begin
                        check(cyc - t_act[id] >= T_RCD, "R5 ACT-COL", cyc - t_act[id], T_RCD);
                        if (cmd_kind == 3'd4 || cmd_kind == 3'd5) ap_pend[id] = 1;
                    end
                endcase
            end
            p_wait = cmd_valid && !cmd_grant;
            p_kind = cmd_kind; p_rank = cmd_rank; p_bank = cmd_bank;
            p_row = cmd_row; p_col = cmd_col;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1
        check(cmd_valid == 0 && req_ready == 1, "R1 reset state", {cmd_valid, req_ready}, 1);
        send(0, 1, 5, 3, 0, 0, 0, "R2 close read");
        send(0, 1, 5, 4, 1, 0, 1, "R9 close again same row");
        send(0, 2, 7, 1, 1, 1, 0, "R3 open first write");
        send(0, 2, 7, 2, 0, 1, 0, "R3 open hit read");
        send(0, 2, 9, 6, 0, 1, 0, "R4 open miss");
        send(0, 3, 4, 8, 0, 2, 1, "R8 close-aggr keep");
        send(0, 3, 4, 9, 0, 2, 0, "R8 close-aggr hit then close");
        send(0, 3, 4, 10, 1, 2, 0, "R9 reopen after AP");
        send(1, 0, 12, 5, 1, 3, 0, "R8 open-aggr close");
        send(1, 0, 12, 7, 0, 3, 1, "R8 open-aggr keep");
        stall = 1;
        send(1, 0, 12, 11, 1, 3, 1, "R10 hit under stall");
        send(1, 0, 30, 2, 0, 1, 0, "R4 miss under stall");
        send(1, 3, 30, 2, 1, 1, 0, "R10 other rank bank");
        stall = 0;
        send(0, 2, 1, 0, 0, 0, 0, "R4 close policy with open row");
        send(0, 2, 1, 1, 0, 0, 0, "R2 close after close");
        while (exp_q.size() != 0 && !finished) @(posedge clk);
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", exp_q.size(), 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule